// File: doc/BRIEF.md
# Link-Side Packet Transmit Sequencer

This block is the link-layer end of a PHY-to-link interface. It sits idle with its control and data outputs disabled, and it watches the 2-bit control lines driven by the PHY. When the PHY hands the interface over, the block drives the lines itself. It can start with an optional single Idle cycle. It then holds the interface while packet bytes are not ready and streams each packet one byte per clock. It closes the packet with a two-cycle tail and then disables its outputs again.

Packet bytes come from a valid/ready source that marks the final byte of each packet. With that final byte the source can ask for a follow-on packet and name that packet's speed. A follow-on request ends the packet with a Hold cycle instead of Idle. When mixed-speed follow-on is enabled, that Hold cycle carries the next speed on the data lines. The block refuses a follow-on that would drop to the lowest speed after a faster packet. In that case, and also on a hold timeout or a source stall in the middle of a packet, it ends ownership with Idle and reports an error code for one cycle.

Top module: `lnk_tx_seq`

## Requirements
- R1: While reset is asserted and after it is released, `lnk_oe`, `err_valid` and `src_ready` are 0, and `lnk_ctl_out` and `lnk_d_out` are all zeros.
- R2: The block enables its outputs only on the first cycle after the PHY drives Grant (11) for one cycle and then Idle (00) for the next cycle. A Grant followed by any value other than Idle does not hand the interface over.
- R3: When `cfg_lead_idle` is 1 at handover, the first driven cycle is Idle (00), and the cycle after it is Hold or Transmit. When `cfg_lead_idle` is 0, the first driven cycle is already Hold or Transmit.
- R4: While no byte is offered, the block drives Hold (01) with data 0. Each accepted byte is driven with Transmit (10) on the next cycle, one byte per cycle and in source order, up to and including the byte flagged last.
- R5: After HOLD_MAX (default 47) consecutive Hold cycles, a byte offered on the next cycle is still sent. Without a byte, that cycle is Idle instead, with `err_valid`=1 and `err_code`=01.
- R6: The cycle after the last byte is the terminator: Hold if `src_more` was set with that byte and the follow-on is accepted, otherwise Idle. One more Idle cycle follows, and then `lnk_oe` returns to 0.
- R7: Speed codes are S100=00, S200=01, S400=10, and 11 is invalid. With `cfg_multispeed`=1, the terminating Hold carries the next speed in the data bits [7:6], with bits [5:0] zero. With `cfg_multispeed`=0, the terminating Hold carries data 0 and the speed requested with the byte is ignored.
- R8: With `cfg_multispeed`=1, a follow-on at S100 after a faster packet, or with code 11, is refused. The terminator is then Idle with `err_valid`=1 and `err_code`=10. The current speed is `cfg_first_spd` at every handover not preceded by an accepted follow-on, and it becomes the accepted next speed otherwise.
- R9: If the source offers no byte after a non-last byte, the next cycle is an Idle terminator with `err_valid`=1 and `err_code`=11, followed by the normal tail.
- R10: The block never drives Grant (11) on `lnk_ctl_out`, and `err_valid` is only ever 1 on a driven Idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multispeed | input | 1 | Enables a speed code on the terminating Hold |
| cfg_lead_idle | input | 1 | Inserts one Idle cycle after handover |
| cfg_first_spd | input | 2 | Speed of the first packet of an ownership |
| src_valid | input | 1 | Source byte valid |
| src_data | input | DATA_W | Source byte |
| src_last | input | 1 | Byte is the last of its packet |
| src_more | input | 1 | With the last byte: a follow-on packet is wanted |
| src_next_spd | input | 2 | With the last byte: speed of the follow-on packet |
| src_ready | output | 1 | Byte accepted at this clock edge |
| phy_ctl_in | input | 2 | Control lines as driven by the PHY |
| lnk_ctl_out | output | 2 | Control lines driven by the link |
| lnk_d_out | output | DATA_W | Data lines driven by the link |
| lnk_oe | output | 1 | Output enable for control and data lines |
| err_valid | output | 1 | One-cycle error flag |
| err_code | output | 2 | Error kind: 01 hold timeout, 10 refused speed, 11 stall |

## Verification
On every cycle, the assertions check these rules: the outputs are enabled only after a Grant-then-Idle pair, a lead Idle is followed by Hold or Transmit, and no Grant is ever driven. They also check that every terminator is followed by exactly one Idle and then a release, that errors appear only on driven Idle, and that an accepted speed change never drops to S100 from a faster speed. Only the bench scenarios can show the exact symbol and byte sequences, the hold timeout boundary at 47 against 48 cycles, and the contents of the speed field. The same applies to the speed carried across a follow-on ownership and reset at a fresh one, and to the error code chosen for each fault.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'b00,
    CTL_HOLD  = 2'b01,
    CTL_XMIT  = 2'b10,
    CTL_GRANT = 2'b11
  } ctl_code_e;

  typedef enum logic [1:0] {
    SPD_100 = 2'b00,
    SPD_200 = 2'b01,
    SPD_400 = 2'b10,
    SPD_BAD = 2'b11
  } spd_code_e;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'b00,
    ERR_HOLD_OVR    = 2'b01,
    ERR_SPD_REFUSED = 2'b10,
    ERR_UNDERRUN    = 2'b11
  } err_code_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LEAD,
    ST_HOLD,
    ST_XMIT,
    ST_TERM,
    ST_TAIL
  } seq_state_e;

  // A follow-on packet may not fall back to the slowest speed, and code 11 is never valid.
  function automatic logic spd_concat_ok(input logic [1:0] cur, input logic [1:0] nxt);
    if (nxt == SPD_BAD) return 1'b0;
    if (nxt == SPD_100 && cur != SPD_100) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/lnk_grant_watch.sv
module lnk_grant_watch
  import lnk_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [1:0] ctl_in,
  output logic       handover
);

  logic saw_grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) saw_grant_q <= 1'b0;
    else        saw_grant_q <= arm && (ctl_in == CTL_GRANT);
  end

  assign handover = arm && saw_grant_q && (ctl_in == CTL_IDLE);

  assert_handover_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    handover |-> $past(ctl_in) == CTL_GRANT);

endmodule

// File: rtl/lnk_hold_timer.sv
module lnk_hold_timer #(
  parameter int HOLD_MAX = 47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic at_limit
);

  localparam int CW = $clog2(HOLD_MAX + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= CW'(1);
    else if (step)  cnt_q <= cnt_next(cnt_q);
  end

  assign at_limit = (cnt_q == CW'(HOLD_MAX));

  assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_limit);

endmodule

// File: rtl/lnk_speed_track.sv
module lnk_speed_track
  import lnk_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_first,
  input  logic [1:0] first_spd,
  input  logic       commit,
  input  logic [1:0] next_spd,
  output logic       concat_ok
);

  logic [1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur_q <= SPD_100;
    else if (load_first) cur_q <= first_spd;
    else if (commit)     cur_q <= next_spd;
  end

  assign concat_ok = spd_concat_ok(cur_q, next_spd);

  assert_no_downshift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !(cur_q == SPD_100 && $past(cur_q) != SPD_100));

endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_MAX = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_multispeed,
  input  logic              cfg_lead_idle,
  input  logic [1:0]        cfg_first_spd,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  input  logic              src_more,
  input  logic [1:0]        src_next_spd,
  output logic              src_ready,
  input  logic [1:0]        phy_ctl_in,
  output logic [1:0]        lnk_ctl_out,
  output logic [DATA_W-1:0] lnk_d_out,
  output logic              lnk_oe,
  output logic              err_valid,
  output logic [1:0]        err_code
);

  localparam int PAD_W = DATA_W - 2;

  function automatic logic [DATA_W-1:0] spd_word(input logic [1:0] spd);
    return {spd, {PAD_W{1'b0}}};
  endfunction

  seq_state_e        state_q, st_d;
  logic [1:0]        ctl_q, ctl_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              oe_q, oe_d;
  logic              errv_q, errv_d;
  logic [1:0]        errc_q, errc_d;
  logic              last_q, more_q, concat_q, concat_d;
  logic [1:0]        nspd_q;

  // Named internal events
  logic ev_handover, ev_take, hold_start, hold_step, hold_full;
  logic spd_load, spd_commit, spd_ok, payload;

  lnk_grant_watch u_grant (
    .clk(clk), .rst_n(rst_n), .arm(state_q == ST_OFF),
    .ctl_in(phy_ctl_in), .handover(ev_handover)
  );

  lnk_hold_timer #(.HOLD_MAX(HOLD_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(hold_start),
    .step(hold_step), .at_limit(hold_full)
  );

  lnk_speed_track u_spd (
    .clk(clk), .rst_n(rst_n), .load_first(spd_load), .first_spd(cfg_first_spd),
    .commit(spd_commit), .next_spd(nspd_q), .concat_ok(spd_ok)
  );

  always_comb begin
    st_d = state_q; ctl_d = CTL_IDLE; dat_d = '0; oe_d = 1'b1;
    errv_d = 1'b0; errc_d = ERR_NONE;
    ev_take = 1'b0; hold_start = 1'b0; hold_step = 1'b0;
    spd_load = 1'b0; spd_commit = 1'b0; concat_d = concat_q; payload = 1'b0;
    case (state_q)
      ST_OFF: begin
        oe_d = 1'b0;
        if (ev_handover) begin
          oe_d = 1'b1;
          spd_load = !concat_q;
          concat_d = 1'b0;
          if (cfg_lead_idle) st_d = ST_LEAD;
          else               payload = 1'b1;
        end
      end
      ST_LEAD, ST_HOLD: payload = 1'b1;
      ST_XMIT: begin
        if (last_q) begin
          st_d = ST_TERM;
          if (more_q && (!cfg_multispeed || spd_ok)) begin
            ctl_d = CTL_HOLD;
            dat_d = cfg_multispeed ? spd_word(nspd_q) : '0;
            spd_commit = cfg_multispeed;
            concat_d = 1'b1;
          end else if (more_q) begin
            errv_d = 1'b1; errc_d = ERR_SPD_REFUSED;
          end
        end else if (src_valid) begin
          ev_take = 1'b1; ctl_d = CTL_XMIT; dat_d = src_data;
        end else begin
          st_d = ST_TERM; errv_d = 1'b1; errc_d = ERR_UNDERRUN;
        end
      end
      ST_TERM: st_d = ST_TAIL;
      ST_TAIL: begin st_d = ST_OFF; oe_d = 1'b0; end
      default: begin st_d = ST_OFF; oe_d = 1'b0; end
    endcase
    if (payload) begin
      if (src_valid) begin
        ev_take = 1'b1; st_d = ST_XMIT; ctl_d = CTL_XMIT; dat_d = src_data;
      end else if (state_q == ST_HOLD && hold_full) begin
        st_d = ST_TERM; errv_d = 1'b1; errc_d = ERR_HOLD_OVR;
      end else begin
        st_d = ST_HOLD; ctl_d = CTL_HOLD;
        hold_start = (state_q != ST_HOLD);
        hold_step  = (state_q == ST_HOLD);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF; ctl_q <= CTL_IDLE; dat_q <= '0; oe_q <= 1'b0;
      errv_q <= 1'b0; errc_q <= ERR_NONE; concat_q <= 1'b0;
      last_q <= 1'b0; more_q <= 1'b0; nspd_q <= SPD_100;
    end else begin
      state_q <= st_d; ctl_q <= ctl_d; dat_q <= dat_d; oe_q <= oe_d;
      errv_q <= errv_d; errc_q <= errc_d; concat_q <= concat_d;
      if (ev_take) begin
        last_q <= src_last; more_q <= src_more; nspd_q <= src_next_spd;
      end
    end
  end

  assign src_ready   = ev_take;
  assign lnk_ctl_out = ctl_q;
  assign lnk_d_out   = dat_q;
  assign lnk_oe      = oe_q;
  assign err_valid   = errv_q;
  assign err_code    = errc_q;

  assert_takeover_after_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_oe) |-> ($past(phy_ctl_in) == CTL_IDLE && $past(phy_ctl_in, 2) == CTL_GRANT));
  assert_lead_idle_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD) |=> (lnk_ctl_out == CTL_HOLD || lnk_ctl_out == CTL_XMIT));
  assert_hold_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (lnk_ctl_out == CTL_HOLD && lnk_d_out == '0));
  assert_tail_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TERM) |=> (lnk_oe && lnk_ctl_out == CTL_IDLE));
  assert_release_after_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |=> !lnk_oe);
  assert_never_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_oe |-> lnk_ctl_out != CTL_GRANT);
  assert_err_on_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (lnk_oe && lnk_ctl_out == CTL_IDLE));

endmodule

// File: tb/lnk_tx_seq_tb_top.sv
module lnk_tx_seq_tb_top;
  import lnk_tx_pkg::*;

  localparam int HMAX = 47;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_multispeed, cfg_lead_idle;
  logic [1:0] cfg_first_spd, src_next_spd, phy_ctl_in, lnk_ctl_out, err_code;
  logic src_valid, src_last, src_more, src_ready, lnk_oe, err_valid;
  logic [7:0] src_data, lnk_d_out;

  lnk_tx_seq #(.DATA_W(8), .HOLD_MAX(HMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_multispeed(cfg_multispeed), .cfg_lead_idle(cfg_lead_idle),
    .cfg_first_spd(cfg_first_spd), .src_valid(src_valid), .src_data(src_data),
    .src_last(src_last), .src_more(src_more), .src_next_spd(src_next_spd),
    .src_ready(src_ready), .phy_ctl_in(phy_ctl_in), .lnk_ctl_out(lnk_ctl_out),
    .lnk_d_out(lnk_d_out), .lnk_oe(lnk_oe), .err_valid(err_valid), .err_code(err_code)
  );

  typedef struct {logic [7:0] d; logic last; logic more; logic [1:0] nspd;} src_item_t;
  typedef struct {logic oe; logic [1:0] ctl; logic [7:0] d; logic ev; logic [1:0] ec; string req;} exp_t;

  src_item_t src_q[$];
  exp_t      exp_q[$];
  int n_checks = 0, n_fail = 0;
  logic src_en = 1'b0;
  logic [1:0] m_speed = SPD_100;
  bit m_concat = 1'b0;

  task automatic check(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin n_fail++; $display("FAIL %s: %s", req, what); end
  endtask

  task automatic push(input logic oe, input logic [1:0] ctl, input logic [7:0] d,
                      input logic ev, input logic [1:0] ec, input string req);
    exp_t e;
    e.oe = oe; e.ctl = ctl; e.d = d; e.ev = ev; e.ec = ec; e.req = req;
    exp_q.push_back(e);
  endtask

  // Source driver: present at negedge, retire just before the next posedge.
  initial begin
    src_valid = 0; src_data = 0; src_last = 0; src_more = 0; src_next_spd = 0;
    forever begin
      @(negedge clk);
      if (src_en && src_q.size() > 0) begin
        src_valid = 1; src_data = src_q[0].d; src_last = src_q[0].last;
        src_more = src_q[0].more; src_next_spd = src_q[0].nspd;
      end else src_valid = 0;
      #8;
      if (src_valid && src_ready) void'(src_q.pop_front());
    end
  end

  // Scoreboard monitor
  initial forever begin
    @(negedge clk); #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      bit ok;
      e = exp_q.pop_front();
      ok = (lnk_oe == e.oe) && (err_valid == e.ev) && (!e.ev || err_code == e.ec) &&
           (!e.oe || (lnk_ctl_out == e.ctl && lnk_d_out == e.d));
      check(ok, e.req, $sformatf("actual oe=%0b ctl=%02b d=%02h err=%0b/%02b expected oe=%0b ctl=%02b d=%02h err=%0b/%02b",
            lnk_oe, lnk_ctl_out, lnk_d_out, err_valid, err_code, e.oe, e.ctl, e.d, e.ev, e.ec));
      check(!(lnk_oe && lnk_ctl_out == CTL_GRANT), "R10",
            $sformatf("actual ctl=%02b expected not 11", lnk_ctl_out));
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    src_en = 0; src_q.delete();
  endtask

  // One bus ownership: handover, optional lead Idle, k Hold cycles, bytes, terminator, tail.
  task automatic own(input bit lead, input int k, input int nbytes, input logic [7:0] base,
                     input bit more, input logic [1:0] nspd, input bit trunc, input string req);
    bit ok;
    for (int i = 0; i < nbytes; i++)
      src_q.push_back('{d: base + 8'(i), last: (i == nbytes - 1) && !trunc, more: more, nspd: nspd});
    if (!m_concat) m_speed = cfg_first_spd;
    m_concat = 0;
    src_en = (lead == 0 && k == 0);
    @(negedge clk) phy_ctl_in = CTL_GRANT;
    @(negedge clk) phy_ctl_in = CTL_IDLE;
    @(posedge clk);
    if (lead) push(1, CTL_IDLE, 0, 0, 0, req);
    for (int i = 0; i < k && i < HMAX; i++) push(1, CTL_HOLD, 0, 0, 0, req);
    if (k > HMAX) begin
      push(1, CTL_IDLE, 0, 1, ERR_HOLD_OVR, "R5");
    end else begin
      for (int i = 0; i < nbytes; i++) push(1, CTL_XMIT, base + 8'(i), 0, 0, req);
      if (trunc) push(1, CTL_IDLE, 0, 1, ERR_UNDERRUN, "R9");
      else if (more) begin
        ok = !cfg_multispeed || (nspd != SPD_BAD && !(nspd == SPD_100 && m_speed != SPD_100));
        if (ok) begin
          push(1, CTL_HOLD, cfg_multispeed ? {nspd, 6'b0} : 8'h00, 0, 0, "R7");
          m_concat = 1;
          if (cfg_multispeed) m_speed = nspd;
        end else push(1, CTL_IDLE, 0, 1, ERR_SPD_REFUSED, "R8");
      end else push(1, CTL_IDLE, 0, 0, 0, "R6");
    end
    push(1, CTL_IDLE, 0, 0, 0, "R6");
    push(0, CTL_IDLE, 0, 0, 0, "R6");
    if ((lead || k > 0) && k <= HMAX) begin
      repeat (int'(lead) + k - 1) @(posedge clk);
      src_en = 1;
    end
    drain();
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; phy_ctl_in = CTL_IDLE; cfg_multispeed = 0; cfg_lead_idle = 0; cfg_first_spd = SPD_400;
    repeat (3) @(negedge clk);
    check(!lnk_oe && !err_valid && !src_ready, "R1",
          $sformatf("actual oe=%0b err=%0b rdy=%0b expected 0/0/0", lnk_oe, err_valid, src_ready));
    rst_n = 1;
    @(negedge clk);
    check(!lnk_oe && !err_valid && lnk_ctl_out == 2'b00 && lnk_d_out == 8'h00, "R1",
          $sformatf("actual oe=%0b ctl=%02b d=%02h expected 0/00/00", lnk_oe, lnk_ctl_out, lnk_d_out));

    // R2: Grant not followed by Idle does not hand over
    @(negedge clk) phy_ctl_in = CTL_GRANT;
    @(negedge clk) phy_ctl_in = CTL_HOLD;
    @(negedge clk) phy_ctl_in = CTL_IDLE;
    @(posedge clk);
    for (int i = 0; i < 3; i++) push(0, CTL_IDLE, 0, 0, 0, "R2");
    drain();

    own(0, 0, 4, 8'h10, 0, SPD_100, 0, "R4");     // immediate data, R2/R4/R6
    cfg_lead_idle = 1;
    own(1, 0, 3, 8'h20, 0, SPD_100, 0, "R3");     // lead Idle then Transmit
    own(1, 3, 2, 8'h30, 0, SPD_100, 0, "R3");     // lead Idle then Hold
    cfg_lead_idle = 0;
    own(0, 5, 2, 8'h40, 0, SPD_100, 0, "R4");
    own(0, HMAX, 2, 8'h50, 0, SPD_100, 0, "R5");  // longest legal hold
    own(0, HMAX + 1, 0, 8'h00, 0, SPD_100, 0, "R5"); // timeout

    // R7: follow-on with multispeed off ignores the requested speed
    own(0, 0, 2, 8'h60, 1, SPD_100, 0, "R7");
    own(0, 0, 2, 8'h68, 0, SPD_100, 0, "R7");

    // R7/R8: multispeed on
    cfg_multispeed = 1;
    own(0, 0, 2, 8'h70, 1, SPD_200, 0, "R7");
    own(0, 0, 2, 8'h78, 1, SPD_100, 0, "R8");     // S200 -> S100 refused
    own(0, 0, 1, 8'h80, 1, SPD_BAD, 0, "R8");     // fresh ownership at S400, code 11 refused
    own(0, 0, 1, 8'h88, 1, SPD_400, 0, "R7");
    own(0, 0, 1, 8'h90, 1, SPD_100, 0, "R8");     // S400 -> S100 refused
    cfg_first_spd = SPD_100;
    own(0, 0, 2, 8'h98, 1, SPD_100, 0, "R8");     // S100 -> S100 accepted
    own(0, 0, 1, 8'hA0, 0, SPD_100, 0, "R6");
    cfg_multispeed = 0;

    own(0, 0, 2, 8'hB0, 0, SPD_100, 1, "R9");     // stall inside a packet

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule